// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Edge Interrupts

This block is a general-purpose I/O port of sixteen pins behind a small register bus that accepts halfword accesses only. Software sets the direction of each pin, the value driven on the pins it owns, and which pins take part in interrupts. Each pin that acts as an input is passed through a synchronizer. The block compares the synchronized value with its value on the previous cycle, and a transition in the chosen direction sets a sticky status bit.

A status bit is cleared by writing 1 to it. The single interrupt line stays high while any status bit is set. The value read back from the pins is gated by a per-pin enable register. The bus has a request, a write enable, a size code, an address and write data. Read data is returned in the same cycle as the request. Any access whose size is not a halfword is dropped.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, output data, direction, edge select, mask and pin enable all read 0xFFFF. Input data and status read 0x0000. irq_o, pin_o and pin_oe_o are all zero.
- R2: pin_oe_o equals the inverse of the direction register, where direction bit 1 means input. pin_o equals output data ANDed with the inverse of direction, so a pin is driven only where its direction bit is 0.
- R3: A read at offset 0x00 returns the synchronized pin inputs ANDed with the pin-enable register (offset 0x18). A pin change becomes visible there two clock edges after it is applied.
- R4: When edge-select bit (offset 0x0C) is 1, a low-to-high transition of that pin sets its status bit. A high-to-low transition does not.
- R5: When edge-select bit is 0, a high-to-low transition sets the status bit. A low-to-high transition does not.
- R6: A status bit is set only when its direction bit is 1 and its mask bit (offset 0x10) is 0. A mask bit of 1 blocks the interrupt.
- R7: Writing to status (offset 0x14) clears each bit written as 1 and leaves bits written as 0 unchanged.
- R8: irq_o is high exactly when at least one status bit is set.
- R9: When a transition event and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R10: Writes to offset 0x00 and to unmapped offsets change no register. Reads of unmapped offsets return zero.
- R11: An access with size_i other than 1 (halfword; 0 is byte, 2 is word) is ignored. Such a write changes nothing, and such a read returns zero.
- R12: Output data (0x04), direction (0x08), edge select, mask and pin enable read back the last halfword written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Access size code, 1 = halfword |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, same cycle |
| pin_i | input | 16 | Pin levels |
| pin_o | output | 16 | Pin drive values |
| pin_oe_o | output | 16 | Per-pin drive enable |
| irq_o | output | 1 | Interrupt, high while any status bit is set |

## Verification
The hardest case to reach is a transition event landing in the same cycle as a write-1-to-clear of the same status bit. The event fires in a fixed cycle behind the synchronizer. The bench changes a pin on a falling clock edge, waits two falling edges so that the change has crossed both synchronizer stages, and then drives the clear write in that same cycle. A control run issues the clear alone. Sweeps over every pin, in both edge polarities and under the direction and mask gates, cover the ordinary set paths.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 8;
  localparam logic [1:0] SIZE_HALF = 2'd1;

  typedef enum logic [ADDR_W-1:0] {
    OFF_IN     = 8'h00,
    OFF_OUT    = 8'h04,
    OFF_DIR    = 8'h08,
    OFF_EDGE   = 8'h0C,
    OFF_MASK   = 8'h10,
    OFF_STATUS = 8'h14,
    OFF_PEN    = 8'h18
  } reg_off_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_o <= '0;
    else         prev_o <= stage_q[STAGES-1];

  assign cur_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int W = 16
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] rise_sel_i,
  output logic [W-1:0] ev_o
);
  logic [W-1:0] rise, fall;
  assign rise = cur_i & ~prev_i;
  assign fall = ~cur_i & prev_i;
  // only input pins with interrupt unmasked
  assign ev_o = dir_i & ~mask_i & ((rise_sel_i & rise) | (~rise_sel_i & fall));
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o,
  output logic         irq_o
);
  logic [W-1:0] status_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | set_i;

  assign status_o = status_q;
  assign irq_o    = |status_q;

  // R7
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(clr_i & ~set_i)) == '0));
  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(set_i)) == $past(set_i)));
  // R6
  no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(set_i)) == '0));
  // R8
  irq_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(|clr_i));
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_pkg::*;
#(
  parameter int N_PINS      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] rdata_o,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_o,
  output logic [N_PINS-1:0] pin_oe_o,
  output logic              irq_o
);
  logic [N_PINS-1:0] out_q, dir_q, edge_q, mask_q, pen_q;
  logic [N_PINS-1:0] cur, prev, ev, status, clr;
  logic              acc_ok, wr_ok, rd_ok;

  assign acc_ok = req_i && (size_i == SIZE_HALF);
  assign wr_ok  = acc_ok && we_i;
  assign rd_ok  = acc_ok && !we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '1;
      dir_q  <= '1;
      edge_q <= '1;
      mask_q <= '1;
      pen_q  <= '1;
    end else if (wr_ok) begin
      case (addr_i)
        OFF_OUT:  out_q  <= wdata_i;
        OFF_DIR:  dir_q  <= wdata_i;
        OFF_EDGE: edge_q <= wdata_i;
        OFF_MASK: mask_q <= wdata_i;
        OFF_PEN:  pen_q  <= wdata_i;
        default:  ;
      endcase
    end
  end

  assign clr = (wr_ok && addr_i == OFF_STATUS) ? wdata_i : '0;

  always_comb begin
    rdata_o = '0;
    if (rd_ok) begin
      case (addr_i)
        OFF_IN:     rdata_o = cur & pen_q;
        OFF_OUT:    rdata_o = out_q;
        OFF_DIR:    rdata_o = dir_q;
        OFF_EDGE:   rdata_o = edge_q;
        OFF_MASK:   rdata_o = mask_q;
        OFF_STATUS: rdata_o = status;
        OFF_PEN:    rdata_o = pen_q;
        default:    rdata_o = '0;
      endcase
    end
  end

  gpio_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i, .rst_ni, .d_i(pin_i), .cur_o(cur), .prev_o(prev)
  );

  gpio_edge_det #(.W(N_PINS)) edge_i (
    .cur_i(cur), .prev_i(prev), .dir_i(dir_q), .mask_i(mask_q),
    .rise_sel_i(edge_q), .ev_o(ev)
  );

  gpio_irq_status #(.W(N_PINS)) stat_i (
    .clk_i, .rst_ni, .set_i(ev), .clr_i(clr), .status_o(status), .irq_o
  );

  assign pin_oe_o = ~dir_q;
  assign pin_o    = out_q & ~dir_q;

  // R2
  dir_to_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && addr_i == OFF_DIR) |=> (pin_oe_o == ~$past(wdata_i)));
  // R11
  bad_size_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && size_i != SIZE_HALF) |=> $stable(out_q) && $stable(dir_q));
endmodule

// File: tb/gpio_edge_port_tb_top.sv
module gpio_edge_port_tb_top;
  logic        clk = 0, rst_ni = 0;
  logic        req = 0, we = 0;
  logic [1:0]  size = 2'd1;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0, rdata, pin_in = '0, pin_o, pin_oe;
  logic        irq;
  int          n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  gpio_edge_port dut_i (
    .clk_i(clk), .rst_ni, .req_i(req), .we_i(we), .size_i(size), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin_in), .pin_o, .pin_oe_o(pin_oe),
    .irq_o(irq)
  );

  task automatic check(string req_tag, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req_tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d, logic [1:0] sz = 2'd1);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d; size = sz;
    @(negedge clk);
    req = 0; we = 0; size = 2'd1;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d, input logic [1:0] sz = 2'd1);
    @(negedge clk);
    req = 1; we = 0; addr = a; size = sz;
    #1 d = rdata;
    req = 0; size = 2'd1;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic set_pins(logic [15:0] v);
    @(negedge clk);
    pin_in = v;
    idle(4);
  endtask

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    idle(3);
    rst_ni = 1;
    idle(2);
    // R1 reset state
    rd(8'h00, v); check("R1 in", v, 16'h0000);
    rd(8'h04, v); check("R1 out", v, 16'hFFFF);
    rd(8'h08, v); check("R1 dir", v, 16'hFFFF);
    rd(8'h0C, v); check("R1 edge", v, 16'hFFFF);
    rd(8'h10, v); check("R1 mask", v, 16'hFFFF);
    rd(8'h14, v); check("R1 status", v, 16'h0000);
    rd(8'h18, v); check("R1 pen", v, 16'hFFFF);
    check("R1 irq", {15'd0, irq}, 16'h0);
    check("R1 pin_o", pin_o, 16'h0);
    check("R1 pin_oe", pin_oe, 16'h0);

    // R12 readback, R2 drive
    wr(8'h04, 16'hA5C3); wr(8'h08, 16'h0F0F);
    rd(8'h04, v); check("R12 out", v, 16'hA5C3);
    rd(8'h08, v); check("R12 dir", v, 16'h0F0F);
    check("R2 pin_o", pin_o, 16'hA5C3 & ~16'h0F0F);
    check("R2 pin_oe", pin_oe, ~16'h0F0F);
    wr(8'h0C, 16'h3C3C); rd(8'h0C, v); check("R12 edge", v, 16'h3C3C);
    wr(8'h10, 16'h1234); rd(8'h10, v); check("R12 mask", v, 16'h1234);

    // R3 input read gated by pin enable; mask all so no status
    wr(8'h10, 16'hFFFF); wr(8'h08, 16'hFFFF);
    wr(8'h18, 16'hFF00);
    @(negedge clk); pin_in = 16'h1234;
    @(negedge clk);
    rd(8'h00, v); check("R3 latency", v, 16'h1200);
    wr(8'h18, 16'h0FF0); rd(8'h00, v); check("R3 gate", v, 16'h0230);
    wr(8'h18, 16'hFFFF);
    set_pins(16'h0000);
    rd(8'h14, v); check("R6 masked none", v, 16'h0000);

    // R4/R5 sweep all pins, three edge patterns
    wr(8'h10, 16'h0000);
    for (int p = 0; p < 3; p++) begin
      logic [15:0] es;
      es = (p == 0) ? 16'hFFFF : (p == 1) ? 16'h0000 : 16'h5A96;
      wr(8'h0C, es);
      for (int i = 0; i < 16; i++) begin
        logic [15:0] b;
        b = 16'h1 << i;
        set_pins(b);
        rd(8'h14, v); check("R4 rise", v, es[i] ? b : 16'h0);
        check("R8 irq rise", {15'd0, irq}, {15'd0, es[i]});
        wr(8'h14, 16'hFFFF);
        set_pins(16'h0000);
        rd(8'h14, v); check("R5 fall", v, es[i] ? 16'h0 : b);
        check("R8 irq fall", {15'd0, irq}, {15'd0, ~es[i]});
        wr(8'h14, 16'hFFFF);
        check("R8 irq clear", {15'd0, irq}, 16'h0);
      end
    end

    // R6 gates: output pins and masked pins never set
    wr(8'h0C, 16'hFFFF);
    wr(8'h08, 16'hF0F0); wr(8'h10, 16'hCCCC);
    set_pins(16'hFFFF);
    rd(8'h14, v); check("R6 gate", v, 16'hF0F0 & ~16'hCCCC);
    // R7 partial clear
    wr(8'h14, 16'h1010);
    rd(8'h14, v); check("R7 partial", v, (16'hF0F0 & ~16'hCCCC) & ~16'h1010);
    check("R8 irq held", {15'd0, irq}, 16'h1);
    wr(8'h14, 16'hFFFF);
    set_pins(16'h0000);
    wr(8'h08, 16'hFFFF); wr(8'h10, 16'h0000);

    // R9 set wins: bit0 already set, new rise + clear same cycle
    set_pins(16'h0001);
    set_pins(16'h0000);
    rd(8'h14, v); check("R9 pre", v, 16'h0001);
    @(negedge clk); pin_in = 16'h0001;
    @(negedge clk); @(negedge clk);
    req = 1; we = 1; addr = 8'h14; wdata = 16'h0001;
    @(negedge clk); req = 0; we = 0;
    rd(8'h14, v); check("R9 set wins", v, 16'h0001);
    wr(8'h14, 16'h0001);
    rd(8'h14, v); check("R7 clear alone", v, 16'h0000);
    set_pins(16'h0000);

    // R10 input reg / unmapped writes ignored, unmapped reads zero
    wr(8'h04, 16'h00FF);
    wr(8'h00, 16'hFFFF);
    rd(8'h00, v); check("R10 in write", v, 16'h0000);
    wr(8'h1C, 16'h1111); wr(8'h05, 16'h2222);
    rd(8'h1C, v); check("R10 unmapped rd", v, 16'h0000);
    rd(8'h04, v); check("R10 out kept", v, 16'h00FF);

    // R11 non-halfword ignored
    wr(8'h04, 16'h1357, 2'd2); wr(8'h04, 16'h2468, 2'd0);
    rd(8'h04, v); check("R11 wr ignored", v, 16'h00FF);
    rd(8'h04, v, 2'd2); check("R11 rd zero", v, 16'h0000);
    rd(8'h08, v, 2'd0); check("R11 rd byte", v, 16'h0000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule